// File: doc/BRIEF.md
# Single-Cycle Integer Core (RV32I Subset)

A compact processor that finishes each instruction in one clock cycle. On every edge it applies the result of the instruction selected by the program counter. The instruction word comes from a small instruction memory and is decoded in the same cycle. Two source registers are read, and an ALU works on registers, an immediate or the PC. A load or store reaches a separate data memory. The chosen result is written back to the register file and the PC moves on. The supported set is ADD, SUB, AND, OR, ADDI, ANDI, ORI, LW, SW, BEQ, JAL, LUI and AUIPC. Every other encoding behaves as a no-op.

Both memories hold whole 32-bit words only and are cleared by reset. A loader port lets a testbench or boot agent fill either memory after reset. While that port is writing, the core is frozen. A read-only observation port returns any register and any word of either memory, so results can be inspected without reaching into the hierarchy.

Top module: `rvs_core`

## Requirements
- R1: While `rst` is high (synchronous, active high), the PC becomes 0, all 32 registers become 0 and every word of both memories becomes 0.
- R2: With `load_we` high, `load_data` is written at the next edge to word `load_addr` of the instruction memory (`load_sel`=0) or the data memory (`load_sel`=1). In that cycle the PC, the registers and the data memory are not changed by the core. `load_sel` also chooses which memory `obs_mem_data` shows.
- R3: Opcode 0110011 performs ADD (funct3 000, funct7 0000000), SUB (funct3 000, funct7 0100000, computed as rs1 minus rs2), AND (funct3 111) and OR (funct3 110) into rd.
- R4: Opcode 0010011 performs ADDI (000), ANDI (111) and ORI (110) with the sign-extended 12-bit immediate in bits [31:20].
- R5: LUI (0110111) writes the immediate in bits [31:12] with twelve zero low bits. AUIPC (0010111) writes the PC plus that value.
- R6: SW (0100011, funct3 010) and LW (0000011, funct3 010) use rs1 plus the sign-extended offset as the byte address and select the word with bits [7:2]. LW writes the loaded word to rd within the same cycle.
- R7: BEQ (1100011, funct3 000) sets the next PC to PC plus the B-immediate when rs1 equals rs2, and to PC+4 otherwise.
- R8: JAL (1101111) writes PC+4 to rd and sets the next PC to PC plus the J-immediate.
- R9: Register 0 always reads 0, and writes that target it are discarded.
- R10: Any other opcode or funct3/funct7 combination writes no register and no memory, and it advances the PC by 4.
- R11: When nothing redirects it, the PC advances by 4 on each edge while the core runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Loader write strobe; freezes the core while high |
| load_sel | input | 1 | 0 = instruction memory, 1 = data memory (write and observe) |
| load_addr | input | 6 | Word index for loader writes |
| load_data | input | 32 | Loader write data |
| obs_reg_addr | input | 5 | Register number to observe |
| obs_reg_data | output | 32 | Value of the observed register |
| obs_mem_addr | input | 6 | Word index to observe |
| obs_mem_data | output | 32 | Word from the memory chosen by `load_sel` |
| pc_o | output | 32 | Current program counter |

## Verification
Control mistakes reach the ports in different ways. A wrong next-PC choice (branch sense, jump target, step size) shows on `pc_o` one edge after the faulty instruction. From then on, every later PC in the trace is also wrong. A wrong operand, immediate slice, ALU operation or write-back source is not visible at once. It stays in a register or memory word until the observation port reads it, so the bench reads back every destination at the end of the program. It also checks that no-ops, skipped instructions and writes to register 0 left their targets untouched.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  typedef enum logic [6:0] {
    OP_REG    = 7'b0110011,
    OP_IMM    = 7'b0010011,
    OP_LOAD   = 7'b0000011,
    OP_STORE  = 7'b0100011,
    OP_BRANCH = 7'b1100011,
    OP_JAL    = 7'b1101111,
    OP_LUI    = 7'b0110111,
    OP_AUIPC  = 7'b0010111
  } opcode_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;
  typedef enum logic [1:0] {A_REG, A_PC, A_ZERO} a_sel_e;

  typedef struct packed {
    logic    reg_we;
    logic    mem_we;
    logic    b_imm;
    a_sel_e  a_sel;
    alu_op_e alu_op;
    wb_sel_e wb_sel;
    logic    is_branch;
    logic    is_jal;
  } ctrl_t;
endpackage

// File: rtl/rvs_wordmem.sv
module rvs_wordmem #(
  parameter int WORDS = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/rvs_regfile.sv
module rvs_regfile
  import rvs_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RAW-1:0]  ra1,
  output logic [XLEN-1:0] rd1,
  input  logic [RAW-1:0]  ra2,
  output logic [XLEN-1:0] rd2,
  input  logic [RAW-1:0]  ra3,
  output logic [XLEN-1:0] rd3
);
  logic [XLEN-1:0] rf [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (we && waddr != '0) begin
      rf[waddr] <= wdata;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : rf[ra1];
  assign rd2 = (ra2 == '0) ? '0 : rf[ra2];
  assign rd3 = (ra3 == '0) ? '0 : rf[ra3];
endmodule

// File: rtl/rvs_alu.sv
module rvs_alu
  import rvs_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/rvs_decode.sv
module rvs_decode
  import rvs_pkg::*;
(
  input  logic [31:0]     instr,
  output ctrl_t           ctrl,
  output logic [XLEN-1:0] imm
);
  logic [2:0] f3;
  logic [6:0] f7;
  assign f3 = instr[14:12];
  assign f7 = instr[31:25];

  always_comb begin
    ctrl = '{reg_we: 1'b0, mem_we: 1'b0, b_imm: 1'b0, a_sel: A_REG,
             alu_op: ALU_ADD, wb_sel: WB_ALU, is_branch: 1'b0, is_jal: 1'b0};
    imm  = '0;
    case (instr[6:0])
      OP_REG: begin
        ctrl.reg_we = 1'b1;
        if (f3 == 3'b000 && f7 == 7'b0000000)      ctrl.alu_op = ALU_ADD;
        else if (f3 == 3'b000 && f7 == 7'b0100000) ctrl.alu_op = ALU_SUB;
        else if (f3 == 3'b111 && f7 == 7'b0000000) ctrl.alu_op = ALU_AND;
        else if (f3 == 3'b110 && f7 == 7'b0000000) ctrl.alu_op = ALU_OR;
        else ctrl.reg_we = 1'b0;
      end
      OP_IMM: begin
        ctrl.reg_we = 1'b1;
        ctrl.b_imm  = 1'b1;
        imm = {{20{instr[31]}}, instr[31:20]};
        case (f3)
          3'b000:  ctrl.alu_op = ALU_ADD;
          3'b111:  ctrl.alu_op = ALU_AND;
          3'b110:  ctrl.alu_op = ALU_OR;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.reg_we = (f3 == 3'b010);
        ctrl.b_imm  = 1'b1;
        ctrl.wb_sel = WB_MEM;
        imm = {{20{instr[31]}}, instr[31:20]};
      end
      OP_STORE: begin
        ctrl.mem_we = (f3 == 3'b010);
        ctrl.b_imm  = 1'b1;
        imm = {{20{instr[31]}}, instr[31:25], instr[11:7]};
      end
      OP_BRANCH: begin
        ctrl.is_branch = (f3 == 3'b000);
        ctrl.alu_op    = ALU_SUB;
        imm = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
      end
      OP_JAL: begin
        ctrl.reg_we = 1'b1;
        ctrl.is_jal = 1'b1;
        ctrl.wb_sel = WB_LINK;
        imm = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
      end
      OP_LUI: begin
        ctrl.reg_we = 1'b1;
        ctrl.b_imm  = 1'b1;
        ctrl.a_sel  = A_ZERO;
        imm = {instr[31:12], 12'b0};
      end
      OP_AUIPC: begin
        ctrl.reg_we = 1'b1;
        ctrl.b_imm  = 1'b1;
        ctrl.a_sel  = A_PC;
        imm = {instr[31:12], 12'b0};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rvs_core.sv
module rvs_core
  import rvs_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int MAW      = $clog2(MEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_we,
  input  logic            load_sel,
  input  logic [MAW-1:0]  load_addr,
  input  logic [XLEN-1:0] load_data,
  input  logic [RAW-1:0]  obs_reg_addr,
  output logic [XLEN-1:0] obs_reg_data,
  input  logic [MAW-1:0]  obs_mem_addr,
  output logic [XLEN-1:0] obs_mem_data,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] pc, pc_plus4, pc_next, instr, imm;
  logic [XLEN-1:0] rs1_v, rs2_v, alu_a, alu_b, alu_y, ld_v, wb_v;
  logic [XLEN-1:0] imem_obs, dmem_obs;
  logic            alu_zero;
  ctrl_t           ctrl;

  rvs_wordmem #(.WORDS(MEM_WORDS), .W(XLEN)) u_imem (
    .clk(clk), .rst(rst),
    .we(load_we && !load_sel), .waddr(load_addr), .wdata(load_data),
    .raddr_a(pc[MAW+1:2]), .rdata_a(instr),
    .raddr_b(obs_mem_addr), .rdata_b(imem_obs)
  );

  rvs_decode u_dec (.instr(instr), .ctrl(ctrl), .imm(imm));

  rvs_regfile u_rf (
    .clk(clk), .rst(rst),
    .we(ctrl.reg_we && !load_we), .waddr(instr[11:7]), .wdata(wb_v),
    .ra1(instr[19:15]), .rd1(rs1_v),
    .ra2(instr[24:20]), .rd2(rs2_v),
    .ra3(obs_reg_addr), .rd3(obs_reg_data)
  );

  always_comb begin
    case (ctrl.a_sel)
      A_PC:    alu_a = pc;
      A_ZERO:  alu_a = '0;
      default: alu_a = rs1_v;
    endcase
  end
  assign alu_b = ctrl.b_imm ? imm : rs2_v;

  rvs_alu u_alu (.op(ctrl.alu_op), .a(alu_a), .b(alu_b), .y(alu_y), .zero(alu_zero));

  rvs_wordmem #(.WORDS(MEM_WORDS), .W(XLEN)) u_dmem (
    .clk(clk), .rst(rst),
    .we(load_we ? load_sel : ctrl.mem_we),
    .waddr(load_we ? load_addr : alu_y[MAW+1:2]),
    .wdata(load_we ? load_data : rs2_v),
    .raddr_a(alu_y[MAW+1:2]), .rdata_a(ld_v),
    .raddr_b(obs_mem_addr), .rdata_b(dmem_obs)
  );

  assign pc_plus4 = pc + XLEN'(4);

  always_comb begin
    case (ctrl.wb_sel)
      WB_MEM:  wb_v = ld_v;
      WB_LINK: wb_v = pc_plus4;
      default: wb_v = alu_y;
    endcase
  end

  assign pc_next = (ctrl.is_jal || (ctrl.is_branch && alu_zero)) ? pc + imm : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst)           pc <= '0;
    else if (!load_we) pc <= pc_next;
  end

  assign pc_o         = pc;
  assign obs_mem_data = load_sel ? dmem_obs : imem_obs;
endmodule

// File: rtl/rvs_core_chk.sv
module rvs_core_chk
  import rvs_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            load_we,
  input logic [XLEN-1:0] pc_o,
  input logic [31:0]     instr,
  input logic [RAW-1:0]  obs_reg_addr,
  input logic [XLEN-1:0] obs_reg_data
);
  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> pc_o == '0);

  // R2
  load_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    load_we |=> $stable(pc_o));

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (obs_reg_addr == '0) |-> (obs_reg_data == '0));

  // R11
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_we && instr[6:0] != OP_BRANCH && instr[6:0] != OP_JAL)
      |=> pc_o == $past(pc_o) + XLEN'(4));

  // R11
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    pc_o[1:0] == 2'b00);
endmodule

bind rvs_core rvs_core_chk u_chk (
  .clk(clk), .rst(rst), .load_we(load_we), .pc_o(pc_o), .instr(instr),
  .obs_reg_addr(obs_reg_addr), .obs_reg_data(obs_reg_data)
);

// File: tb/test_rvs_core.sv
`timescale 1ns/1ps
module test_rvs_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_we = 1'b0, load_sel = 1'b0;
  logic [5:0]  load_addr = '0, obs_mem_addr = '0;
  logic [31:0] load_data = '0;
  logic [4:0]  obs_reg_addr = '0;
  logic [31:0] obs_reg_data, obs_mem_data, pc_o;

  int n_chk = 0, n_fail = 0, n_push = 0, n_done = 0;

  typedef struct {
    bit          is_mem;
    int          idx;
    logic [31:0] val;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  rvs_core i_rvs_core (
    .clk(clk), .rst(rst), .load_we(load_we), .load_sel(load_sel),
    .load_addr(load_addr), .load_data(load_data),
    .obs_reg_addr(obs_reg_addr), .obs_reg_data(obs_reg_data),
    .obs_mem_addr(obs_mem_addr), .obs_mem_data(obs_mem_data), .pc_o(pc_o)
  );

  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(logic [11:0] im, logic [4:0] rs1, logic [2:0] f3,
                                        logic [4:0] rd, logic [6:0] op);
    return {im, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_s(logic [11:0] im, logic [4:0] rs2, logic [4:0] rs1);
    return {im[11:5], rs2, rs1, 3'b010, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(logic [12:0] im, logic [4:0] rs2, logic [4:0] rs1);
    return {im[12], im[10:5], rs2, rs1, 3'b000, im[4:1], im[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(logic [20:0] im, logic [4:0] rd);
    return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic load_word(logic sel, logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    load_we = 1'b1; load_sel = sel; load_addr = a; load_data = d;
    @(posedge clk);
  endtask

  task automatic expect_item(bit is_mem, int idx, logic [31:0] v, string req);
    item_t it;
    it.is_mem = is_mem; it.idx = idx; it.val = v; it.req = req;
    sb_q.push_back(it);
    n_push++;
  endtask

  // monitor: pops expected items and compares against the observation port
  initial begin
    forever begin
      item_t it;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      @(negedge clk);
      if (it.is_mem) begin
        load_sel = 1'b1; obs_mem_addr = 6'(it.idx);
        #1 check(it.req, obs_mem_data, it.val);
      end else begin
        obs_reg_addr = 5'(it.idx);
        #1 check(it.req, obs_reg_data, it.val);
      end
      n_done++;
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] prog [22];
    prog[0]  = enc_i(12'd5,   5'd0, 3'b000, 5'd1, 7'b0010011);
    prog[1]  = enc_i(12'hFFD, 5'd0, 3'b000, 5'd2, 7'b0010011);
    prog[2]  = enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd3);
    prog[3]  = enc_r(7'h20, 5'd2, 5'd1, 3'b000, 5'd4);
    prog[4]  = enc_r(7'h00, 5'd2, 5'd1, 3'b111, 5'd5);
    prog[5]  = enc_r(7'h00, 5'd2, 5'd1, 3'b110, 5'd6);
    prog[6]  = enc_i(12'h0F0, 5'd6, 3'b111, 5'd7, 7'b0010011);
    prog[7]  = enc_i(12'hFF0, 5'd1, 3'b110, 5'd8, 7'b0010011);
    prog[8]  = {20'hABCDE, 5'd9,  7'b0110111};
    prog[9]  = {20'h00001, 5'd10, 7'b0010111};
    prog[10] = enc_s(12'd12,  5'd4, 5'd0);
    prog[11] = enc_s(12'hFFC, 5'd6, 5'd7);
    prog[12] = enc_i(12'd20,  5'd0, 3'b010, 5'd11, 7'b0000011);
    prog[13] = enc_i(12'd7,   5'd0, 3'b000, 5'd0,  7'b0010011);
    prog[14] = enc_b(13'd8, 5'd2, 5'd1);
    prog[15] = enc_b(13'd8, 5'd3, 5'd3);
    prog[16] = enc_i(12'd99,  5'd0, 3'b000, 5'd12, 7'b0010011);
    prog[17] = enc_j(21'd8, 5'd13);
    prog[18] = enc_i(12'd1,   5'd0, 3'b000, 5'd14, 7'b0010011);
    prog[19] = enc_i(12'd12,  5'd0, 3'b010, 5'd15, 7'b0000011);
    prog[20] = enc_i(12'd0,   5'd0, 3'b000, 5'd16, 7'b1100111);
    prog[21] = enc_j(21'd0, 5'd0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pc after reset", pc_o, 32'h0);
    obs_reg_addr = 5'd1; load_sel = 1'b1; obs_mem_addr = 6'd5;
    #1 check("R1 reg cleared", obs_reg_data, 32'h0);
    check("R1 dmem cleared", obs_mem_data, 32'h0);

    // first load, then reset again to prove the clear
    rst = 1'b0; load_we = 1'b1; load_sel = 1'b1; load_addr = 6'd5; load_data = 32'hDEADBEEF;
    @(posedge clk);
    @(negedge clk);
    load_we = 1'b0; load_sel = 1'b1; obs_mem_addr = 6'd5;
    #1 check("R2 loader write visible", obs_mem_data, 32'hDEADBEEF);
    check("R2 pc frozen during load", pc_o, 32'h0);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1 check("R1 memory cleared by reset", obs_mem_data, 32'h0);

    // release reset straight into loading
    rst = 1'b0; load_we = 1'b1;
    for (int i = 0; i < 22; i++) load_word(1'b0, 6'(i), prog[i]);
    load_word(1'b1, 6'd5, 32'h12345678);
    @(negedge clk);
    load_sel = 1'b0; obs_mem_addr = 6'd17;
    #1 check("R2 pc held through loading", pc_o, 32'h0);
    check("R2 instruction word readback", obs_mem_data, prog[17]);
    load_we = 1'b0;

    for (int k = 1; k <= 25; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 1)  check("R11 sequential step", pc_o, 32'd4);
      if (k == 15) check("R7 beq not taken", pc_o, 32'd60);
      if (k == 16) check("R7 beq taken", pc_o, 32'd68);
      if (k == 17) check("R8 jal target", pc_o, 32'd76);
      if (k == 19) check("R10 no-op advances pc", pc_o, 32'd84);
      if (k == 25) check("R8 self jump holds pc", pc_o, 32'd84);
    end

    expect_item(0, 1,  32'd5,        "R4 addi");
    expect_item(0, 2,  32'hFFFFFFFD, "R4 addi negative");
    expect_item(0, 3,  32'd2,        "R3 add");
    expect_item(0, 4,  32'd8,        "R3 sub");
    expect_item(0, 5,  32'd5,        "R3 and");
    expect_item(0, 6,  32'hFFFFFFFD, "R3 or");
    expect_item(0, 7,  32'h000000F0, "R4 andi");
    expect_item(0, 8,  32'hFFFFFFF5, "R4 ori");
    expect_item(0, 9,  32'hABCDE000, "R5 lui");
    expect_item(0, 10, 32'h00001024, "R5 auipc");
    expect_item(0, 11, 32'h12345678, "R6 lw preloaded");
    expect_item(0, 0,  32'h0,        "R9 x0 write ignored");
    expect_item(0, 12, 32'h0,        "R7 skipped by branch");
    expect_item(0, 13, 32'd72,       "R8 jal link");
    expect_item(0, 14, 32'h0,        "R8 skipped by jal");
    expect_item(0, 15, 32'd8,        "R6 lw after sw");
    expect_item(0, 16, 32'h0,        "R10 unsupported no write");
    expect_item(1, 3,  32'd8,        "R6 sw word 3");
    expect_item(1, 59, 32'hFFFFFFFD, "R6 sw negative offset");
    expect_item(1, 5,  32'h12345678, "R6 untouched word");
    wait (n_done == n_push);
    @(negedge clk);
    finish_run();
  end
endmodule